// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register Block

This block holds the host-visible control state of a network controller. It decodes writes to a command register into one-cycle action pulses for the engines that do the work. Those engines are transmit, receive, timer, reset, buffer-resource fetch and address-filter loading. It keeps a pending bit per action until the owning engine reports completion. It also merges event inputs into an interrupt status register and drives one level-sensitive interrupt line from the masked status.

The host reaches the block through a single-cycle register port: a write strobe, an address and write data, plus a combinational read-data output. Configuration, receive and transmit control, the end-of-buffer count, a fixed revision word and a small set of error tally counters sit behind the same port. Each of these has its own write rule.

Top module: `nic_cmdirq`

## Requirements
- R1: After hardware reset the command register reads 0x0094 (reset 0x0080, stop-timer 0x0010, rx-disable 0x0004). Mask and status read 0, the end-of-buffer count reads 0x02F8, the revision reads 0x0004, and `irq` is low.
- R2: `irq` is high exactly when some bit is set in both mask and status. It follows a register change in the same cycle the register changes.
- R3: A status write clears only those bits that are written as one and are currently set. A bit that `evt_set` raises in the same cycle as a host clear stays set.
- R4: A status write that clears a set buffer-exhausted bit (bit 5, 0x0020) produces a read-resource pulse (`act_pulse` bit 8) in the next cycle. Writing that bit while it is clear produces no pulse.
- R5: Mask writes keep only bits 14:0.
- R6: While the reset bit (0x0080) is set, a command write without that bit clears only the reset bit. It changes no other command bit and produces no action pulse.
- R7: Any other command write ORs (data AND 0x03bf) into the command register. In the following cycle `act_pulse` equals (data AND 0x03bf) for exactly one cycle. Pulse bits use the command encoding: halt-tx 0x1, transmit 0x2, rx-disable 0x4, rx-enable 0x8, stop-timer 0x10, start-timer 0x20, reset 0x80, read-resource 0x100, load-filter 0x200.
- R8: An accepted rx-enable clears rx-disable and an accepted rx-disable clears rx-enable. Start-timer and stop-timer each clear the other in the same way. When both members of a pair arrive in one write, both end clear.
- R9: An accepted reset command clears load-filter, read-resource, transmit and halt-tx, and sets reset and rx-disable.
- R10: `done_tx`, `done_rsrc` and `done_cam` clear the transmit (0x2), read-resource (0x100) and load-filter (0x200) pending bits. A command write setting the same bit in that cycle wins.
- R11: The configuration register stores (data AND 0xbfff) only while the reset bit is set. At other times writes to it are ignored.
- R12: Transmit control keeps bits 15:12 and receive control keeps bits 15:5.
- R13: A write to any tally counter stores the one's complement of the written data.
- R14: Address map: 0 command, 1 mask, 2 status, 3 configuration, 4 receive control, 5 transmit control, 6 end-of-buffer count, 7 revision (read-only), 8 and up the tally counters. Writes to the revision are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_we | input | 1 | Host write strobe, one write per asserted cycle |
| host_addr | input | 4 | Register address for reads and writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed register (combinational) |
| evt_set | input | 16 | Internal events, each sets its status bit |
| done_tx | input | 1 | Transmit engine completion |
| done_rsrc | input | 1 | Resource-fetch engine completion |
| done_cam | input | 1 | Address-filter load completion |
| act_pulse | output | 16 | One-cycle action requests, command bit encoding |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions can occur in one cycle. The first is an event raising a status bit while the host writes one to clear that same bit. The bench drives both at one falling edge and expects the bit to survive with `irq` still high. The second is an engine completion arriving in the cycle a new command re-arms the same pending bit. The bench asserts `done_cam` together with a load-filter command write and expects the pending bit to remain set. In both cases the later read-back of status or command is the verdict.

// File: rtl/nic_cmdirq_pkg.sv
package nic_cmdirq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_CFG    = 4'd3;
  localparam logic [ADDR_W-1:0] A_RXCTL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_TXCTL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_EOB    = 4'd6;
  localparam logic [ADDR_W-1:0] A_REV    = 4'd7;
  localparam int                TALLY_BASE = 8;

  // command bit positions (also the action pulse encoding)
  localparam int B_HALT   = 0;
  localparam int B_TX     = 1;
  localparam int B_RXOFF  = 2;
  localparam int B_RXON   = 3;
  localparam int B_TSTOP  = 4;
  localparam int B_TSTART = 5;
  localparam int B_RST    = 7;
  localparam int B_RSRC   = 8;
  localparam int B_CAM    = 9;

  // status bit that requests a resource fetch when acknowledged
  localparam int B_BUFEX  = 5;

  localparam logic [REG_W-1:0] CMD_KEEP     = 16'h03bf;
  localparam logic [REG_W-1:0] CMD_HW_INIT  = 16'h0094;
  localparam logic [REG_W-1:0] MASK_KEEP    = 16'h7fff;
  localparam logic [REG_W-1:0] CFG_KEEP     = 16'hbfff;
  localparam logic [REG_W-1:0] TXCTL_KEEP   = 16'hf000;
  localparam logic [REG_W-1:0] RXCTL_KEEP   = 16'hffe0;

  // Merge an accepted command into the current command word.
  function automatic logic [REG_W-1:0] cmd_apply(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] raw);
    logic [REG_W-1:0] req;
    logic [REG_W-1:0] c;
    req = raw & CMD_KEEP;
    c   = cur | req;
    if (req[B_RXOFF])  c[B_RXON]   = 1'b0;
    if (req[B_RXON])   c[B_RXOFF]  = 1'b0;
    if (req[B_TSTOP])  c[B_TSTART] = 1'b0;
    if (req[B_TSTART]) c[B_TSTOP]  = 1'b0;
    if (req[B_RST]) begin
      c[B_CAM]   = 1'b0;
      c[B_RSRC]  = 1'b0;
      c[B_TX]    = 1'b0;
      c[B_HALT]  = 1'b0;
      c[B_RST]   = 1'b1;
      c[B_RXOFF] = 1'b1;
    end
    return c;
  endfunction

  // Write-one-to-clear limited to set bits, with event sets taking priority.
  function automatic logic [REG_W-1:0] w1c_merge(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] clr,
                                                 input logic [REG_W-1:0] set);
    return (cur & ~(clr & cur)) | set;
  endfunction

  function automatic logic [REG_W-1:0] tally_store(input logic [REG_W-1:0] v);
    return ~v;
  endfunction
endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
  import nic_cmdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_cmd,
  input  logic [REG_W-1:0] wdata,
  input  logic             done_tx,
  input  logic             done_rsrc,
  input  logic             done_cam,
  input  logic             rsrc_ack,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] act_q,
  output logic             cmd_accept,
  output logic             cmd_leave
);
  logic [REG_W-1:0] done_vec;
  logic [REG_W-1:0] cmd_d;
  logic [REG_W-1:0] act_d;

  assign cmd_leave  = we_cmd && cmd_q[B_RST] && !wdata[B_RST];
  assign cmd_accept = we_cmd && !cmd_leave;

  always_comb begin
    done_vec         = '0;
    done_vec[B_TX]   = done_tx;
    done_vec[B_RSRC] = done_rsrc;
    done_vec[B_CAM]  = done_cam;
  end

  always_comb begin
    cmd_d = cmd_q & ~done_vec;
    act_d = '0;
    if (cmd_leave) begin
      cmd_d[B_RST] = 1'b0;
    end else if (cmd_accept) begin
      cmd_d = cmd_apply(cmd_d, wdata);
      act_d = wdata & CMD_KEEP;
    end
    if (rsrc_ack) act_d[B_RSRC] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_HW_INIT;
      act_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/nic_stat_unit.sv
module nic_stat_unit
  import nic_cmdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_mask,
  input  logic             we_stat,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt_set,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] stat_q,
  output logic             rsrc_ack,
  output logic             irq
);
  logic [REG_W-1:0] clr_req;

  assign clr_req  = we_stat ? wdata : '0;
  assign rsrc_ack = we_stat && wdata[B_BUFEX] && stat_q[B_BUFEX];
  assign irq      = |(mask_q & stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (we_mask) mask_q <= wdata & MASK_KEEP;
      stat_q <= w1c_merge(stat_q, clr_req, evt_set);
    end
  end
endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
  import nic_cmdirq_pkg::*;
#(
  parameter int               N_TALLY   = 3,
  parameter logic [REG_W-1:0] EOB_RESET = 16'h02F8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_we,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [REG_W-1:0]              wdata,
  input  logic                          in_reset,
  output logic [REG_W-1:0]              cfg_q,
  output logic [REG_W-1:0]              rxctl_q,
  output logic [REG_W-1:0]              txctl_q,
  output logic [REG_W-1:0]              eob_q,
  output logic [N_TALLY-1:0][REG_W-1:0] tally_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rxctl_q <= '0;
      txctl_q <= '0;
      eob_q   <= EOB_RESET;
    end else if (host_we) begin
      if (host_addr == A_CFG && in_reset) cfg_q <= wdata & CFG_KEEP;
      if (host_addr == A_RXCTL) rxctl_q <= wdata & RXCTL_KEEP;
      if (host_addr == A_TXCTL) txctl_q <= wdata & TXCTL_KEEP;
      if (host_addr == A_EOB)   eob_q   <= wdata;
    end
  end

  for (genvar g = 0; g < N_TALLY; g++) begin : g_tally
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(TALLY_BASE + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tally_q[g] <= '0;
      else if (host_we && host_addr == MY_ADDR) tally_q[g] <= tally_store(wdata);
    end
  end
endmodule

// File: rtl/nic_cmdirq.sv
module nic_cmdirq
  import nic_cmdirq_pkg::*;
#(
  parameter int               N_TALLY   = 3,
  parameter logic [REG_W-1:0] REV_ID    = 16'h0004,
  parameter logic [REG_W-1:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [3:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [15:0]       evt_set,
  input  logic              done_tx,
  input  logic              done_rsrc,
  input  logic              done_cam,
  output logic [15:0]       act_pulse,
  output logic              irq
);
  logic [REG_W-1:0] cmd_q, mask_q, stat_q, cfg_q, rxctl_q, txctl_q, eob_q;
  logic [N_TALLY-1:0][REG_W-1:0] tally_q;
  logic we_cmd, we_mask, we_stat;
  logic cmd_accept, cmd_leave, rsrc_ack;

  assign we_cmd  = host_we && host_addr == A_CMD;
  assign we_mask = host_we && host_addr == A_MASK;
  assign we_stat = host_we && host_addr == A_STAT;

  nic_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n), .we_cmd(we_cmd), .wdata(host_wdata),
    .done_tx(done_tx), .done_rsrc(done_rsrc), .done_cam(done_cam),
    .rsrc_ack(rsrc_ack), .cmd_q(cmd_q), .act_q(act_pulse),
    .cmd_accept(cmd_accept), .cmd_leave(cmd_leave)
  );

  nic_stat_unit u_stat (
    .clk(clk), .rst_n(rst_n), .we_mask(we_mask), .we_stat(we_stat),
    .wdata(host_wdata), .evt_set(evt_set), .mask_q(mask_q),
    .stat_q(stat_q), .rsrc_ack(rsrc_ack), .irq(irq)
  );

  nic_cfg_bank #(.N_TALLY(N_TALLY), .EOB_RESET(EOB_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .wdata(host_wdata), .in_reset(cmd_q[B_RST]), .cfg_q(cfg_q),
    .rxctl_q(rxctl_q), .txctl_q(txctl_q), .eob_q(eob_q), .tally_q(tally_q)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CMD:   host_rdata = cmd_q;
      A_MASK:  host_rdata = mask_q;
      A_STAT:  host_rdata = stat_q;
      A_CFG:   host_rdata = cfg_q;
      A_RXCTL: host_rdata = rxctl_q;
      A_TXCTL: host_rdata = txctl_q;
      A_EOB:   host_rdata = eob_q;
      A_REV:   host_rdata = REV_ID;
      default: begin
        for (int i = 0; i < N_TALLY; i++)
          if (host_addr == ADDR_W'(TALLY_BASE + i)) host_rdata = tally_q[i];
      end
    endcase
  end
endmodule

// File: rtl/nic_cmdirq_chk.sv
module nic_cmdirq_chk
  import nic_cmdirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_we,
  input logic [3:0]       host_addr,
  input logic [15:0]      host_wdata,
  input logic [15:0]      evt_set,
  input logic [15:0]      act_pulse,
  input logic             irq,
  input logic [15:0]      cmd_q,
  input logic [15:0]      mask_q,
  input logic [15:0]      stat_q,
  input logic [15:0]      cfg_q,
  input logic             cmd_accept,
  input logic             cmd_leave,
  input logic             rsrc_ack
);
  a_r2_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_set) != 16'h0 || $past(host_we && host_addr == A_MASK)));

  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(evt_set) & ~stat_q) == 16'h0));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(evt_set)) == 16'h0));

  a_r4_rsrc_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!act_pulse[B_RSRC] ||
               $past(rsrc_ack) || $past(cmd_accept && host_wdata[B_RSRC])));

  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == A_MASK) |=> (mask_q == ($past(host_wdata) & 16'h7fff)));

  a_r6_leave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_leave |=> (act_pulse == 16'h0 && !cmd_q[B_RST]));

  a_r8_rx_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_q[B_RXON], cmd_q[B_RXOFF]}));

  a_r8_timer_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_q[B_TSTART], cmd_q[B_TSTOP]}));

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && host_wdata[B_RST]) |=>
      (cmd_q[B_RST] && cmd_q[B_RXOFF] && !cmd_q[B_TX] && !cmd_q[B_HALT] &&
       !cmd_q[B_RSRC] && !cmd_q[B_CAM]));

  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == A_CFG && !cmd_q[B_RST]) |=> $stable(cfg_q));
endmodule

bind nic_cmdirq nic_cmdirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .evt_set(evt_set), .act_pulse(act_pulse),
  .irq(irq), .cmd_q(cmd_q), .mask_q(mask_q), .stat_q(stat_q), .cfg_q(cfg_q),
  .cmd_accept(cmd_accept), .cmd_leave(cmd_leave), .rsrc_ack(rsrc_ack)
);

// File: tb/nic_cmdirq_bench.sv
module nic_cmdirq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic [15:0] evt_set = 16'h0;
  logic        done_tx = 1'b0, done_rsrc = 1'b0, done_cam = 1'b0;
  logic [15:0] act_pulse;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_cmdirq u_nic_cmdirq (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .evt_set(evt_set),
    .done_tx(done_tx), .done_rsrc(done_rsrc), .done_cam(done_cam),
    .act_pulse(act_pulse), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic pulse_evt(input logic [15:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = 16'h0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd0, v); check("R1 command init", v, 16'h0094);
    rd(4'd1, v); check("R1 mask init", v, 16'h0000);
    rd(4'd2, v); check("R1 status init", v, 16'h0000);
    rd(4'd6, v); check("R1 eob init", v, 16'h02F8);
    rd(4'd7, v); check("R1 revision", v, 16'h0004);
    check("R1 irq low", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_cfg_and_leave;
    logic [15:0] v;
    wr(4'd3, 16'hFFFF); rd(4'd3, v); check("R11 cfg in reset", v, 16'hBFFF);
    wr(4'd0, 16'h0008);
    check("R6 no pulse on leave", act_pulse, 16'h0000);
    rd(4'd0, v); check("R6 only reset cleared", v, 16'h0014);
    wr(4'd3, 16'h1234); rd(4'd3, v); check("R11 cfg locked", v, 16'hBFFF);
  endtask

  task automatic t_cmd_pairs;
    logic [15:0] v;
    wr(4'd0, 16'h0008);
    check("R7 rx-enable pulse", act_pulse, 16'h0008);
    rd(4'd0, v); check("R8 rx-enable clears rx-disable", v, 16'h0018);
    @(negedge clk); check("R7 pulse lasts one cycle", act_pulse, 16'h0000);
    wr(4'd0, 16'h0020); rd(4'd0, v); check("R8 start clears stop", v, 16'h0028);
    wr(4'd0, 16'h0024); rd(4'd0, v); check("R8 rx-disable clears rx-enable", v, 16'h0024);
    wr(4'd0, 16'h000C);
    check("R7 both rx pulses", act_pulse, 16'h000C);
    rd(4'd0, v); check("R8 both rx bits end clear", v, 16'h0020);
  endtask

  task automatic t_pending;
    logic [15:0] v;
    wr(4'd0, 16'hFF02);
    check("R7 masked pulse", act_pulse, 16'h0302);
    rd(4'd0, v); check("R7 pending set", v, 16'h0322);
    @(negedge clk); done_tx = 1'b1; @(negedge clk); done_tx = 1'b0;
    rd(4'd0, v); check("R10 done_tx clears transmit", v, 16'h0320);
    @(negedge clk);
    done_cam = 1'b1; host_we = 1'b1; host_addr = 4'd0; host_wdata = 16'h0200;
    @(negedge clk);
    done_cam = 1'b0; host_we = 1'b0;
    rd(4'd0, v); check("R10 set wins over done", v, 16'h0320);
    @(negedge clk); done_cam = 1'b1; done_rsrc = 1'b1;
    @(negedge clk); done_cam = 1'b0; done_rsrc = 1'b0;
    rd(4'd0, v); check("R10 done clears pending", v, 16'h0020);
  endtask

  task automatic t_soft_reset;
    logic [15:0] v;
    wr(4'd0, 16'h0382);
    check("R9 pulses", act_pulse, 16'h0382);
    rd(4'd0, v); check("R9 soft reset state", v, 16'h00A4);
  endtask

  task automatic t_status;
    logic [15:0] v;
    wr(4'd1, 16'hFFFF); rd(4'd1, v); check("R5 mask keep", v, 16'h7FFF);
    pulse_evt(16'h0031);
    rd(4'd2, v); check("R3 events set", v, 16'h0031);
    check("R2 irq high", {15'h0, irq}, 16'h0001);
    wr(4'd2, 16'h0003);
    check("R4 no pulse without bit 5", act_pulse, 16'h0000);
    rd(4'd2, v); check("R3 clear only set bits", v, 16'h0030);
    wr(4'd2, 16'h0020);
    check("R4 ack pulse", act_pulse, 16'h0100);
    rd(4'd2, v); check("R3 bit5 cleared", v, 16'h0010);
    wr(4'd2, 16'h0020);
    check("R4 no pulse when clear", act_pulse, 16'h0000);
    @(negedge clk);
    evt_set = 16'h0010; host_we = 1'b1; host_addr = 4'd2; host_wdata = 16'h0010;
    @(negedge clk);
    evt_set = 16'h0; host_we = 1'b0;
    rd(4'd2, v); check("R3 event wins over clear", v, 16'h0010);
    check("R2 irq kept", {15'h0, irq}, 16'h0001);
    wr(4'd2, 16'h0010);
    check("R2 irq low after clear", {15'h0, irq}, 16'h0000);
    wr(4'd1, 16'h0000);
    pulse_evt(16'h0001);
    check("R2 masked off", {15'h0, irq}, 16'h0000);
    wr(4'd1, 16'h0001);
    check("R2 unmask raises", {15'h0, irq}, 16'h0001);
  endtask

  task automatic t_misc;
    logic [15:0] v;
    wr(4'd5, 16'hFFFF); rd(4'd5, v); check("R12 tx control", v, 16'hF000);
    wr(4'd4, 16'hFFFF); rd(4'd4, v); check("R12 rx control", v, 16'hFFE0);
    wr(4'd9, 16'h1234); rd(4'd9, v); check("R13 tally complement", v, 16'hEDCB);
    wr(4'd10, 16'h0000); rd(4'd10, v); check("R13 tally zero", v, 16'hFFFF);
    wr(4'd7, 16'h5555); rd(4'd7, v); check("R14 revision read-only", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_and_leave();
    t_cmd_pairs();
    t_pending();
    t_soft_reset();
    t_status();
    t_misc();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule